// File: doc/BRIEF.md
# Adaptation Header Receive Checker

This block sits on the receive path of a cell adaptation layer. Each incoming unit is a run of `UNIT_BYTES` bytes (48 by default). The first byte carries a small protected header: an indication bit, a 3-bit sequence count, a 3-bit cyclic check and an even parity bit. The block checks that header and can repair a single flipped bit. It then strips the header and forwards the remaining payload bytes unchanged, one cycle after they arrive.

Repair is governed by a two-state mode machine. In correction mode a single-bit error is fixed. Any error moves the machine to detection mode, where no repair is attempted. The first clean header returns it to correction mode. The recovered fields, a field-valid flag and the error class are registered when the header byte is accepted. They are held until the next header, so they are already in place when the first payload byte appears and stay steady for the whole unit. Input bytes are counted only on cycles with `in_valid` high, so idle cycles may occur anywhere in a unit.

Top module: `sn_hdr_rx`

## Requirements
- R1: The header byte is never forwarded. Each of the following `UNIT_BYTES-1` payload bytes appears on `out_data` with `out_valid` high on the cycle after it is accepted, with its value unchanged. `out_first` is high only with the first payload byte of a unit.
- R2: Header layout is bit 7 indication, bits 6:4 sequence count, bits 3:1 check and bit 0 parity. The check is the remainder of the 4-bit field {bit7..bit4}·x^3 divided by x^3+x+1, with the highest power in bit 3. Parity makes all eight bits XOR to zero. A header that satisfies both gives `out_sn_ok`=1, both error flags 0, and fields equal to the received ones.
- R3: After reset no byte is output, the machine is in correction mode (`out_corr_mode`=1), and `out_sn_ok` and both error flags are 0.
- R4: In correction mode, a single flipped bit among bits 7:1 (nonzero syndrome, failing parity) is corrected. The result is `out_sn_ok`=1 and `out_err_single`=1, and the machine goes to detection mode.
- R5: A flipped parity bit alone (zero syndrome, failing parity) is classed as a single-bit error. The fields are unchanged, and in correction mode the header is valid.
- R6: A nonzero syndrome with passing parity is a multi-bit error. It gives `out_err_multi`=1 and `out_sn_ok`=0, and the machine goes to detection mode.
- R7: In detection mode, any error gives `out_sn_ok`=0 and presents the received fields uncorrected. The machine stays in detection mode.
- R8: In detection mode, an error-free header is valid and returns the machine to correction mode.
- R9: The fields and flags change only on the clock edge that accepts a header byte and are held through the unit. Idle input cycles do not advance the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Payload byte strobe |
| out_first | output | 1 | First payload byte of a unit |
| out_data | output | 8 | Payload byte |
| out_csi | output | 1 | Recovered indication bit |
| out_seq | output | 3 | Recovered sequence count |
| out_sn_ok | output | 1 | Header fields valid |
| out_err_single | output | 1 | Header had a single-bit error |
| out_err_multi | output | 1 | Header had a multi-bit error |
| out_corr_mode | output | 1 | Mode machine in correction mode |

## Verification
The bench flips each of the seven protected header bits in turn. A decoder with a wrong syndrome table would repair the wrong bit, and the fields would then fail to match the clean header. It sends a header with only the parity bit flipped. A design that treats a zero syndrome as clean would leave `out_err_single` low or keep correction mode. It sends double-bit errors in both modes, and single-bit errors while in detection mode, where a design that still corrects would wrongly raise `out_sn_ok`. Idle gaps are inserted inside units. A byte counter that ran on idle cycles would then strip a payload byte or forward a header.

// File: rtl/sn_hdr_pkg.sv
package sn_hdr_pkg;
    localparam int HDR_W  = 8;
    localparam int CW_LEN = 7;
    localparam int SYN_W  = 3;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_ONE  = 2'd1,
        ERR_MANY = 2'd2
    } err_cls_e;

    typedef enum logic {
        MODE_CORR   = 1'b0,
        MODE_DETECT = 1'b1
    } mode_e;

    // x^i reduced modulo x^3 + x + 1
    function automatic logic [SYN_W-1:0] gpow(input int i);
        logic [SYN_W-1:0] r;
        r = 3'b001;
        for (int k = 0; k < i; k++) begin
            r = {r[1:0], 1'b0} ^ (r[2] ? 3'b011 : 3'b000);
        end
        return r;
    endfunction
endpackage

// File: rtl/sn_hdr_decode.sv
module sn_hdr_decode
    import sn_hdr_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    output logic [SYN_W-1:0] syn,
    output logic             par_bad,
    output err_cls_e         cls,
    output logic [HDR_W-1:0] fixed
);
    always_comb begin
        syn = '0;
        for (int i = 0; i < CW_LEN; i++) begin
            if (hdr[i+1]) syn = syn ^ gpow(i);
        end
        par_bad = ^hdr;

        if (!par_bad && syn == '0)      cls = ERR_NONE;
        else if (par_bad)               cls = ERR_ONE;
        else                            cls = ERR_MANY;

        fixed = hdr;
        if (par_bad) begin
            if (syn == '0) begin
                fixed[0] = ~hdr[0];
            end else begin
                for (int i = 0; i < CW_LEN; i++) begin
                    if (gpow(i) == syn) fixed[i+1] = ~hdr[i+1];
                end
            end
        end
    end
endmodule

// File: rtl/sn_hdr_mode.sv
module sn_hdr_mode
    import sn_hdr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hdr_stb,
    input  err_cls_e cls,
    output logic     corr_mode
);
    mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (hdr_stb) begin
            mode_d = (cls == ERR_NONE) ? MODE_CORR : MODE_DETECT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_CORR;
        else        mode_q <= mode_d;
    end

    assign corr_mode = (mode_q == MODE_CORR);
endmodule

// File: rtl/sn_hdr_rx.sv
module sn_hdr_rx
    import sn_hdr_pkg::*;
#(
    parameter int UNIT_BYTES = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [HDR_W-1:0] in_data,
    output logic             out_valid,
    output logic             out_first,
    output logic [HDR_W-1:0] out_data,
    output logic             out_csi,
    output logic [2:0]       out_seq,
    output logic             out_sn_ok,
    output logic             out_err_single,
    output logic             out_err_multi,
    output logic             out_corr_mode
);
    localparam int CNT_W = (UNIT_BYTES > 2) ? $clog2(UNIT_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UNIT_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ov;
        logic             of;
        logic [HDR_W-1:0] od;
        logic             csi;
        logic [2:0]       seq;
        logic             ok;
        logic             es;
        logic             em;
    } st_t;

    st_t st_d, st_q;

    logic             hdr_stb;
    logic [SYN_W-1:0] syn;
    logic             par_bad;
    err_cls_e         cls;
    logic [HDR_W-1:0] fixed;
    logic             corr_mode;

    assign hdr_stb = in_valid && (st_q.cnt == '0);

    sn_hdr_decode u_dec (
        .hdr     (in_data),
        .syn     (syn),
        .par_bad (par_bad),
        .cls     (cls),
        .fixed   (fixed)
    );

    sn_hdr_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_stb   (hdr_stb),
        .cls       (cls),
        .corr_mode (corr_mode)
    );

    always_comb begin
        logic [HDR_W-1:0] use_hdr;
        st_d    = st_q;
        st_d.ov = 1'b0;
        st_d.of = 1'b0;
        use_hdr = (corr_mode && cls == ERR_ONE) ? fixed : in_data;
        if (in_valid) begin
            if (st_q.cnt == '0) begin
                st_d.csi = use_hdr[7];
                st_d.seq = use_hdr[6:4];
                st_d.es  = (cls == ERR_ONE);
                st_d.em  = (cls == ERR_MANY);
                st_d.ok  = (cls == ERR_NONE) || (cls == ERR_ONE && corr_mode);
            end else begin
                st_d.ov = 1'b1;
                st_d.od = in_data;
                st_d.of = (st_q.cnt == CNT_W'(1));
            end
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid      = st_q.ov;
    assign out_first      = st_q.of;
    assign out_data       = st_q.od;
    assign out_csi        = st_q.csi;
    assign out_seq        = st_q.seq;
    assign out_sn_ok      = st_q.ok;
    assign out_err_single = st_q.es;
    assign out_err_multi  = st_q.em;
    assign out_corr_mode  = corr_mode;
endmodule

// File: rtl/sn_hdr_rx_chk.sv
module sn_hdr_rx_chk #(
    parameter int UNIT_BYTES = 48
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic       out_first,
    input logic [7:0] out_data,
    input logic       out_csi,
    input logic [2:0] out_seq,
    input logic       out_sn_ok,
    input logic       out_err_single,
    input logic       out_err_multi,
    input logic       out_corr_mode
);
    localparam int CW = (UNIT_BYTES > 2) ? $clog2(UNIT_BYTES) : 1;
    logic [CW-1:0] ccnt;
    logic          hdr_seen;

    always_ff @(posedge clk) begin
        if (!rst_n)        ccnt <= '0;
        else if (in_valid) ccnt <= (ccnt == CW'(UNIT_BYTES - 1)) ? '0 : ccnt + 1'b1;
    end
    assign hdr_seen = in_valid && (ccnt == '0);

    p_strip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_seen |=> !out_valid);
    p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ccnt != '0) |=> (out_valid && out_data == $past(in_data)));
    p_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ccnt == CW'(1)) |=> out_first);
    p_first_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid);
    p_class_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_err_single && out_err_multi));
    p_corr_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_seen && out_corr_mode) |=> (out_sn_ok == !out_err_multi));
    p_detect_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_seen && !out_corr_mode) |=> (out_sn_ok == !(out_err_single || out_err_multi)));
    p_mode_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_seen |=> (out_corr_mode == !(out_err_single || out_err_multi)));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_seen |=> $stable({out_csi, out_seq, out_sn_ok, out_err_single,
                               out_err_multi, out_corr_mode}));
endmodule

bind sn_hdr_rx sn_hdr_rx_chk #(.UNIT_BYTES(UNIT_BYTES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_data        (in_data),
    .out_valid      (out_valid),
    .out_first      (out_first),
    .out_data       (out_data),
    .out_csi        (out_csi),
    .out_seq        (out_seq),
    .out_sn_ok      (out_sn_ok),
    .out_err_single (out_err_single),
    .out_err_multi  (out_err_multi),
    .out_corr_mode  (out_corr_mode)
);

// File: tb/sn_hdr_rx_bench.sv
module sn_hdr_rx_bench;
    localparam int UB = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid, out_first, out_csi, out_sn_ok;
    logic       out_err_single, out_err_multi, out_corr_mode;
    logic [7:0] out_data;
    logic [2:0] out_seq;

    always #2 clk = ~clk;

    sn_hdr_rx #(.UNIT_BYTES(UB)) u_sn_hdr_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_first(out_first), .out_data(out_data),
        .out_csi(out_csi), .out_seq(out_seq), .out_sn_ok(out_sn_ok),
        .out_err_single(out_err_single), .out_err_multi(out_err_multi),
        .out_corr_mode(out_corr_mode)
    );

    typedef struct packed { logic first; logic [7:0] data; } dexp_t;
    typedef struct packed {
        logic csi; logic [2:0] seq; logic ok; logic es; logic em; logic mode; logic [3:0] req;
    } hexp_t;

    dexp_t dq[$];
    hexp_t hq[$];
    hexp_t cur;
    logic  have_cur = 1'b0;
    logic  model_corr = 1'b1;
    logic  gaps = 1'b0;
    logic  done = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    int    gap_ctr = 0;
    int    total = 0;
    int    bad = 0;

    function automatic string rname(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // long division by x^3+x+1 (1011)
    function automatic logic [2:0] crc3(input logic [3:0] m);
        logic [6:0] v;
        v = {m, 3'b000};
        for (int b = 6; b >= 3; b--) begin
            if (v[b]) v = v ^ (7'b0001011 << (b - 3));
        end
        return v[2:0];
    endfunction

    function automatic logic [7:0] mkhdr(input logic csi, input logic [2:0] seq);
        logic [6:0] c;
        c = {csi, seq, crc3({csi, seq})};
        return {c, ^c};
    endfunction

    task automatic drive_byte(input logic [7:0] d);
        if (gaps && (gap_ctr % 5 == 3)) begin
            in_valid = 1'b0;
            @(posedge clk); #1;
        end
        gap_ctr++;
        in_valid = 1'b1;
        in_data  = d;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic send_unit(input logic csi, input logic [2:0] seq,
                             input logic [7:0] mask, input logic [3:0] req);
        logic [7:0] clean, rx;
        hexp_t      e;
        int         n;
        clean = mkhdr(csi, seq);
        rx    = clean ^ mask;
        n     = $countones(mask);
        e.req = req;
        if (n == 0) begin
            e.ok = 1'b1; e.es = 1'b0; e.em = 1'b0;
            e.csi = clean[7]; e.seq = clean[6:4]; e.mode = 1'b1;
        end else if (n == 1) begin
            e.es = 1'b1; e.em = 1'b0; e.mode = 1'b0;
            e.ok = model_corr;
            e.csi = model_corr ? clean[7] : rx[7];
            e.seq = model_corr ? clean[6:4] : rx[6:4];
        end else begin
            e.ok = 1'b0; e.es = 1'b0; e.em = 1'b1; e.mode = 1'b0;
            e.csi = rx[7]; e.seq = rx[6:4];
        end
        model_corr = e.mode;
        hq.push_back(e);
        drive_byte(rx);
        for (int b = 0; b < UB - 1; b++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            dq.push_back({(b == 0), lfsr});
            drive_byte(lfsr);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (dq.size() == 0) begin
                chk(1'b0, "R1", "unexpected payload byte", 1, 0);
            end else begin
                dexp_t d;
                d = dq.pop_front();
                chk(out_data == d.data, "R1", "payload data", out_data, d.data);
                chk(out_first == d.first, "R1", "first flag", out_first, d.first);
                if (out_first) begin
                    if (hq.size() == 0) begin
                        chk(1'b0, "R1", "first byte with no header", 1, 0);
                    end else begin
                        cur = hq.pop_front();
                        have_cur = 1'b1;
                        chk(out_csi == cur.csi, rname(cur.req), "csi", out_csi, cur.csi);
                        chk(out_seq == cur.seq, rname(cur.req), "seq", out_seq, cur.seq);
                        chk(out_sn_ok == cur.ok, rname(cur.req), "sn_ok", out_sn_ok, cur.ok);
                        chk(out_err_single == cur.es, rname(cur.req), "err_single", out_err_single, cur.es);
                        chk(out_err_multi == cur.em, rname(cur.req), "err_multi", out_err_multi, cur.em);
                        chk(out_corr_mode == cur.mode, rname(cur.req), "mode", out_corr_mode, cur.mode);
                    end
                end else if (have_cur) begin
                    // R9: fields held through the unit
                    chk({out_csi, out_seq, out_sn_ok, out_err_single, out_err_multi} ==
                        {cur.csi, cur.seq, cur.ok, cur.es, cur.em}, "R9", "held fields",
                        {out_csi, out_seq, out_sn_ok, out_err_single, out_err_multi},
                        {cur.csi, cur.seq, cur.ok, cur.es, cur.em});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state
        chk(out_valid == 1'b0, "R3", "out_valid after reset", out_valid, 0);
        chk(out_corr_mode == 1'b1, "R3", "mode after reset", out_corr_mode, 1);
        chk(out_sn_ok == 1'b0, "R3", "sn_ok after reset", out_sn_ok, 0);
        chk({out_err_single, out_err_multi} == 2'b00, "R3", "error flags after reset",
            {out_err_single, out_err_multi}, 0);
        @(posedge clk); #1;

        send_unit(1'b0, 3'd0, 8'h00, 4'd2);   // R2 clean
        send_unit(1'b1, 3'd5, 8'h00, 4'd2);   // R2 clean
        send_unit(1'b0, 3'd3, 8'h20, 4'd4);   // R4 corrected, to detection
        send_unit(1'b1, 3'd6, 8'h80, 4'd7);   // R7 single in detection
        send_unit(1'b0, 3'd1, 8'h0A, 4'd7);   // R7 double in detection
        send_unit(1'b1, 3'd2, 8'h00, 4'd8);   // R8 back to correction
        send_unit(1'b0, 3'd7, 8'h01, 4'd5);   // R5 parity bit only
        send_unit(1'b1, 3'd4, 8'h00, 4'd8);   // R8
        send_unit(1'b1, 3'd1, 8'h50, 4'd6);   // R6 double in correction
        send_unit(1'b0, 3'd6, 8'h00, 4'd8);   // R8
        send_unit(1'b0, 3'd2, 8'h01, 4'd7);   // R5 in correction, then R7 below
        send_unit(1'b1, 3'd3, 8'h01, 4'd7);   // R7 parity-only error in detection
        send_unit(1'b0, 3'd0, 8'h00, 4'd8);   // R8
        gaps = 1'b1;                          // R9 idle gaps inside units
        for (int p = 1; p < 8; p++) begin
            send_unit(p[0], 3'(p), 8'(1 << p), 4'd4);   // R4 each protected bit
            send_unit(~p[0], 3'(7 - p), 8'h00, 4'd8);
        end
        send_unit(1'b1, 3'd7, 8'h00, 4'd9);
        in_valid = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(dq.size() == 0, "R1", "payload bytes left", dq.size(), 0);
        chk(hq.size() == 0, "R1", "headers left", hq.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule